// File: doc/BRIEF.md
# Cascaded Two-Controller Interrupt Acknowledge

This block joins two 8-line interrupt controllers, one master and one slave, behind a single CPU interrupt line. Request lines 0–7 go to the master and lines 8–15 go to the slave. The slave's pending state is forwarded into master input 2, so the slave's requests compete with the master's own lines at that position. Within each controller, the lowest-numbered pending line wins.

When the CPU strobes acknowledge, the block resolves the master winner and registers an 8-bit vector. If the winner is the cascade input, the slave is also acknowledged and the slave's base is used for the vector. When a controller that is asked for a line has none pending, it supplies its line-7 vector as a spurious code.

Each controller has a byte-wide trigger register that selects edge or level capture per line. Some bits of each trigger register are hard-wired to edge mode and cannot be changed. The vector bases are parameters and default to 0x20 for the master and 0x28 for the slave.

Top module: `pic_cascade`

## Requirements
- R1: Request line n (0–15) is served by controller n/8 on input n mod 8. A served request yields the vector base + (n mod 8), with master base 0x20 and slave base 0x28.
- R2: Inside a controller the lowest-numbered pending input wins. On the master, the cascade input 2 therefore outranks master lines 3–7 and ranks below lines 0–1.
- R3: A line in edge mode (trigger bit 0) latches on a rising input edge. It stays pending after the input drops, and the acknowledge that serves it clears it.
- R4: A line in level mode (trigger bit 1) is pending exactly while its input is high, one cycle later. An acknowledge does not clear it.
- R5: int_o is high exactly when the master holds at least one pending input. It goes high on the clock edge after a master edge is captured, and one edge later for a slave request.
- R6: On an acknowledge whose master winner is not input 2, vec_o shows master base + winner from the clock edge that samples ack_i.
- R7: While the slave holds a pending line and no acknowledge is in progress, master input 2 is set on every clock. An acknowledge with master winner 2 gives slave base + slave winner and acknowledges that slave line.
- R8: An acknowledge with no master request gives master base + 7 (0x27) and changes no pending state.
- R9: An acknowledge that reaches the slave while the slave has nothing pending gives slave base + 7 (0x2F). This happens, for example, after a level request has dropped.
- R10: A written trigger byte is ANDed with a fixed mask: 0xF8 on the master and 0xDE on the slave. Master lines 0–2 and slave lines 0 and 5 always stay in edge mode.
- R11: After reset both trigger registers are all-edge, nothing is pending, int_o is low and vec_o is 0.
- R12: After an acknowledge, the next pending request is presented. int_o stays high and the following acknowledge returns the next winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Request lines; 0–7 master, 8–15 slave |
| ack_i | input | 1 | CPU acknowledge strobe, one cycle per acknowledge |
| trig_we_i | input | 2 | Trigger register write enable; bit 0 master, bit 1 slave |
| trig_wdata_i | input | 8 | Trigger byte; bit k = 1 selects level mode for input k |
| int_o | output | 1 | CPU interrupt request |
| vec_o | output | 8 | Vector registered on each acknowledge |

## Verification
A table applies single master lines, single slave lines and mixed patterns, each from a clean reset. These patterns separate the line-to-controller mapping, the priority order inside each controller, and the ranking of the cascade input against master lines on both sides of it. The empty pattern tells a spurious 0x27 apart from a real line-7 request.

Directed sequences then cover several behaviours. Repeated acknowledges show whether edge lines clear and level lines persist. Writes of 0xFF to each trigger register expose the unprogrammable bits, because those lines still clear after one acknowledge. A dropped level request on the slave produces the slave spurious code. Two slave requests pending together show that the cascade input re-arms after the first acknowledge.

// File: rtl/pic_cas_pkg.sv
package pic_cas_pkg;
  localparam int LINES     = 8;
  localparam int IDX_W     = $clog2(LINES);
  localparam int NUM_CTRL  = 2;
  localparam int CASC_LINE = 2;
  localparam int SPUR_LINE = LINES - 1;

  localparam logic [LINES-1:0] MASTER_TRIG_MASK = 8'hF8;
  localparam logic [LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE;

  function automatic logic [IDX_W-1:0] first_set(input logic [LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) r = i[IDX_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import pic_cas_pkg::*;
#(
  parameter logic [LINES-1:0] TRIG_MASK = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] pulse_i,
  input  logic             trig_we_i,
  input  logic [LINES-1:0] trig_wdata_i,
  input  logic             ack_i,
  output logic             has_win_o,
  output logic [IDX_W-1:0] win_o,
  output logic [LINES-1:0] irr_o
);
  logic [LINES-1:0] trig_q, last_q, irr_q, irr_d, rise, clr;

  assign rise      = req_i & ~last_q;
  assign has_win_o = |irr_q;
  assign win_o     = first_set(irr_q);
  assign irr_o     = irr_q;

  always_comb begin
    clr = '0;
    if (ack_i && has_win_o) clr[win_o] = 1'b1;
    for (int i = 0; i < LINES; i++) begin
      if (trig_q[i]) irr_d[i] = req_i[i];
      else           irr_d[i] = (irr_q[i] & ~clr[i]) | rise[i] | pulse_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      last_q <= '0;
      irr_q  <= '0;
    end else begin
      last_q <= req_i;
      irr_q  <= irr_d;
      if (trig_we_i) trig_q <= trig_wdata_i & TRIG_MASK;
    end
  end

  // R10
  trig_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q & ~TRIG_MASK) == '0);

  // R4
  level_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && has_win_o && trig_q[win_o] && req_i[win_o] && !trig_we_i
    |=> irr_q[$past(win_o)]);

  // R3
  edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && has_win_o && !trig_q[win_o] && !rise[win_o] && !pulse_i[win_o] && !trig_we_i
    |=> !irr_q[$past(win_o)]);
endmodule

// File: rtl/pic_vec_sel.sv
module pic_vec_sel
  import pic_cas_pkg::*;
#(
  parameter logic [7:0] M_BASE = 8'h20,
  parameter logic [7:0] S_BASE = 8'h28
) (
  input  logic             ack_i,
  input  logic             m_has_i,
  input  logic [IDX_W-1:0] m_win_i,
  input  logic             s_has_i,
  input  logic [IDX_W-1:0] s_win_i,
  output logic             ack_m_o,
  output logic             ack_s_o,
  output logic [7:0]       vec_o
);
  localparam logic [IDX_W-1:0] CASC = IDX_W'(CASC_LINE);
  localparam logic [IDX_W-1:0] SPUR = IDX_W'(SPUR_LINE);

  logic to_slave;
  assign to_slave = m_has_i && (m_win_i == CASC);
  assign ack_m_o  = ack_i && m_has_i;
  assign ack_s_o  = ack_i && to_slave;

  always_comb begin
    if (!m_has_i)      vec_o = M_BASE + 8'(SPUR);
    else if (to_slave) vec_o = S_BASE + 8'(s_has_i ? s_win_i : SPUR);
    else               vec_o = M_BASE + 8'(m_win_i);
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_cas_pkg::*;
#(
  parameter logic [7:0] M_BASE = 8'h20,
  parameter logic [7:0] S_BASE = 8'h28
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CTRL*LINES-1:0] irq_i,
  input  logic                      ack_i,
  input  logic [NUM_CTRL-1:0]       trig_we_i,
  input  logic [LINES-1:0]          trig_wdata_i,
  output logic                      int_o,
  output logic [7:0]                vec_o
);
  logic [NUM_CTRL-1:0]                has_win, unit_ack;
  logic [NUM_CTRL-1:0][IDX_W-1:0]     win;
  logic [NUM_CTRL-1:0][LINES-1:0]     irr, pulse;
  logic                               casc_set, ack_m, ack_s;
  logic [7:0]                         vec_d, vec_q;

  // slave pending re-arms master cascade input each non-ack cycle
  assign casc_set = has_win[1] && !ack_i;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [LINES-1:0] MASK = (g == 0) ? MASTER_TRIG_MASK : SLAVE_TRIG_MASK;
    if (g == 0) begin : g_casc
      assign pulse[g] = LINES'(casc_set) << CASC_LINE;
    end else begin : g_nocasc
      assign pulse[g] = '0;
    end
    pic_unit #(.TRIG_MASK(MASK)) u_unit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (irq_i[g*LINES +: LINES]),
      .pulse_i     (pulse[g]),
      .trig_we_i   (trig_we_i[g]),
      .trig_wdata_i(trig_wdata_i),
      .ack_i       (unit_ack[g]),
      .has_win_o   (has_win[g]),
      .win_o       (win[g]),
      .irr_o       (irr[g])
    );
  end

  pic_vec_sel #(.M_BASE(M_BASE), .S_BASE(S_BASE)) u_sel (
    .ack_i  (ack_i),
    .m_has_i(has_win[0]),
    .m_win_i(win[0]),
    .s_has_i(has_win[1]),
    .s_win_i(win[1]),
    .ack_m_o(ack_m),
    .ack_s_o(ack_s),
    .vec_o  (vec_d)
  );

  assign unit_ack = {ack_s, ack_m};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_q <= '0;
    else if (ack_i) vec_q <= vec_d;
  end

  assign vec_o = vec_q;
  assign int_o = has_win[0];

  // R8
  spurious_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !int_o |=> vec_o == M_BASE + 8'(SPUR_LINE));

  // R7
  cascade_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_win[1] && !ack_i |=> irr[0][CASC_LINE]);

  // R7
  slave_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_ack[1] |-> unit_ack[0]);

  // R6
  master_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && int_o && irr[0][0] |=> vec_o == M_BASE);
endmodule

// File: tb/pic_cascade_bench.sv
module pic_cascade_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_TBL = 9;
  // {irq pattern, expected first vector}
  localparam logic [23:0] TBL [N_TBL] = '{
    {16'h0001, 8'h20}, {16'h0080, 8'h27}, {16'h0100, 8'h28},
    {16'h8000, 8'h2F}, {16'h0018, 8'h23}, {16'h0208, 8'h29},
    {16'h0202, 8'h21}, {16'hC000, 8'h2E}, {16'h0000, 8'h27}
  };

  logic        clk = 0, rst_ni = 0, ack_i = 0;
  logic [15:0] irq_i = '0;
  logic [1:0]  trig_we_i = '0;
  logic [7:0]  trig_wdata_i = '0;
  logic        int_o;
  logic [7:0]  vec_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cascade u_pic_cascade (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .ack_i(ack_i),
    .trig_we_i(trig_we_i), .trig_wdata_i(trig_wdata_i),
    .int_o(int_o), .vec_o(vec_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    irq_i = '0; ack_i = 0; trig_we_i = '0;
    rst_ni = 0; idle(1); rst_ni = 1; idle(1);
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp);
    ack_i = 1; idle(1); ack_i = 0;
    check(req, vec_o, exp);
    idle(1);
  endtask

  task automatic wr_trig(input logic [1:0] sel, input logic [7:0] d);
    trig_we_i = sel; trig_wdata_i = d; idle(1); trig_we_i = '0;
  endtask

  initial begin
    idle(200000);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(1);
    rst_ni = 1; idle(1);
    // R11 reset state
    check("R11 int", 8'(int_o), 8'h0);
    check("R11 vec", vec_o, 8'h00);

    // R1 R2 R6 R7 R8: table walk
    for (int k = 0; k < N_TBL; k++) begin
      do_reset();
      irq_i = TBL[k][23:8];
      idle(3);
      do_ack("R1/R2 table", TBL[k][7:0]);
    end

    // R3 edge hold then clear; R8 no state change
    do_reset();
    irq_i = 16'h0020; idle(1); irq_i = '0; idle(1);
    check("R5 int after edge", 8'(int_o), 8'h1);
    do_ack("R3 edge served", 8'h25);
    check("R3 cleared", 8'(int_o), 8'h0);
    do_ack("R8 spurious", 8'h27);

    // R12 next pending presented
    do_reset();
    irq_i = 16'h0003; idle(2);
    do_ack("R12 first", 8'h20);
    check("R12 int kept", 8'(int_o), 8'h1);
    do_ack("R12 second", 8'h21);
    check("R12 drained", 8'(int_o), 8'h0);

    // R4 level mode on master line 5
    do_reset();
    wr_trig(2'b01, 8'h20);
    irq_i = 16'h0020; idle(2);
    do_ack("R4 level first", 8'h25);
    do_ack("R4 level kept", 8'h25);
    irq_i = '0; idle(1);
    check("R4 level drop", 8'(int_o), 8'h0);

    // R10 master mask: line 0 stays edge, line 3 becomes level
    do_reset();
    wr_trig(2'b01, 8'hFF);
    irq_i = 16'h0009; idle(2);
    do_ack("R10 m line0", 8'h20);
    do_ack("R10 m line3", 8'h23);
    do_ack("R10 m line3 level", 8'h23);

    // R10 slave mask: slave line 0 stays edge
    do_reset();
    wr_trig(2'b10, 8'hFF);
    irq_i = 16'h0100; idle(3);
    do_ack("R10 s line0", 8'h28);
    check("R10 s line0 cleared", 8'(int_o), 8'h0);
    do_ack("R10 s spurious master", 8'h27);

    // R4 slave level line 9 kept, R9 slave spurious after drop
    do_reset();
    wr_trig(2'b10, 8'h02);
    irq_i = 16'h0200; idle(3);
    do_ack("R4 s level", 8'h29);
    idle(1);
    do_ack("R4 s level kept", 8'h29);
    irq_i = '0; idle(3);
    check("R9 cascade held", 8'(int_o), 8'h1);
    do_ack("R9 slave spurious", 8'h2F);
    check("R9 drained", 8'(int_o), 8'h0);

    // R7 two slave requests: cascade re-arms
    do_reset();
    irq_i = 16'h0300; idle(3);
    do_ack("R7 slave first", 8'h28);
    check("R7 rearmed", 8'(int_o), 8'h1);
    do_ack("R7 slave second", 8'h29);
    idle(1);
    check("R7 drained", 8'(int_o), 8'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule